// File: doc/BRIEF.md
# Cluster Centroid Calculator

This block computes the centre of one pixel cluster at a time. Pixel addresses arrive grouped by cluster on a valid/ready stream. Each beat carries a row and a column slot in a ring of window columns, and a marker on the final beat of the cluster. The block keeps its own store of 8-bit time-over-threshold charge, with one entry per window pixel. The store is filled through a plain write port while hits are loaded into the window. When a hit address is accepted, the block reads that pixel's charge from the store.

The column slot is turned into an absolute column from two values: the ring slot that holds the oldest column (`win_head`) and the absolute column of that slot (`win_base`). Two sets of sums are kept, one unweighted and one weighted by charge. When the cluster closes, two sequential restoring dividers run side by side. They produce x (absolute column) and y (row), each with 4 fraction bits.

A mode pin selects between the plain mean and the charge-weighted mean. A weighted cluster whose total charge is zero gives the plain mean instead. The result waits on the output until it is taken. No new cluster is accepted before that happens.

Back-pressure rules:
- An input beat is taken on a cycle where `in_valid` and `in_ready` are both high.
- `in_ready` is low from the closing beat until the result has been taken.
- `out_valid` holds, with steady data, until `out_ready` is seen.

Top module: `centroid_unit`

## Requirements
- R1: An input beat is taken only on a cycle with `in_valid` and `in_ready` both high. `in_ready` and `out_valid` are never high together.
- R2: After the beat that has `in_last` high is taken, `in_ready` stays low until the result has been taken. Input offered in that time is ignored. `in_ready` is high again on the cycle after an `out_valid`/`out_ready` handshake.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_x` and `out_y` remain unchanged on the next cycle.
- R4: With `mode_weighted` = 0, `out_x` = floor(16·Σcol / n) and `out_y` = floor(16·Σrow / n). Here n is the number of hits, and each output is an unsigned value with 4 fraction bits. The integer part of the result always fits the coordinate width.
- R5: With `mode_weighted` = 1, each hit is weighted by the 8-bit charge stored for its (row, column slot): `out_x` = floor(16·Σq·col / Σq) and `out_y` = floor(16·Σq·row / Σq).
- R6: In weighted mode, a cluster whose stored charges are all zero produces the R4 result.
- R7: A write with `wr_en` high stores `wr_tot` at (`wr_row`, `wr_col`). Hits accepted in any later cycle use that value, and a later write to the same pixel replaces it.
- R8: The absolute column of a hit is (`win_base` + ((`in_col` − `win_head`) mod 8)) mod 128, taken at the cycle the hit is accepted.
- R9: The mode is sampled on the first beat of a cluster. Changes to `mode_weighted` during the rest of that cluster have no effect on its result.
- R10: Out of reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_weighted | input | 1 | 1 = charge-weighted mean, 0 = plain mean |
| win_head | input | 3 | Ring slot holding the oldest window column |
| win_base | input | 7 | Absolute column of the ring slot `win_head` |
| wr_en | input | 1 | Charge store write enable |
| wr_row | input | 4 | Charge store write row |
| wr_col | input | 3 | Charge store write column slot |
| wr_tot | input | 8 | Charge value to store |
| in_valid | input | 1 | Hit beat valid |
| in_ready | output | 1 | Block can take a hit beat |
| in_row | input | 4 | Hit row |
| in_col | input | 3 | Hit column slot in the ring |
| in_last | input | 1 | Final hit of the cluster |
| out_valid | output | 1 | Centre result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_x | output | 11 | Column centre, 7 integer and 4 fraction bits |
| out_y | output | 8 | Row centre, 4 integer and 4 fraction bits |

## Verification
The assertions assume that a cluster never holds more than 64 hits. They also assume that every accepted hit addresses a row inside the window, and that each pixel's charge was written in an earlier cycle than the cycle its hit is accepted. The stimulus keeps clusters to at most 9 hits and uses only rows 0 to 15. It loads the whole charge store before the first cluster and writes later updates only between clusters. Because the weighted and plain means both lie within the span of the coordinates being averaged, the upper quotient bits stay zero under these conditions.

// File: rtl/centroid_pkg.sv
package centroid_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_LAUNCH,
    ST_WAIT,
    ST_SHOW
  } cstate_t;
endpackage

// File: rtl/charge_store.sv
module charge_store #(
  parameter int ROWS = 16,
  parameter int NCOL = 8,
  parameter int TOTW = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(NCOL)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RW-1:0]   wrow,
  input  logic [CW-1:0]   wcol,
  input  logic [TOTW-1:0] wdata,
  input  logic [RW-1:0]   rrow,
  input  logic [CW-1:0]   rcol,
  output logic [TOTW-1:0] rdata
);
  localparam int DEPTH = ROWS * NCOL;

  logic [TOTW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{wrow, wcol}] <= wdata;
  end

  // Asynchronous read: the charge is available in the cycle the hit is taken.
  assign rdata = mem[{rrow, rcol}];
endmodule

// File: rtl/restoring_div.sv
module restoring_div #(
  parameter int NW   = 22,
  parameter int DW   = 15,
  parameter int FRAC = 4,
  localparam int LW  = NW + FRAC,
  localparam int IW  = $clog2(LW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic [LW-1:0] quot
);
  logic [LW-1:0] dvd;
  logic [DW-1:0] rem;
  logic [IW-1:0] cnt;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          ge;

  // One quotient bit per cycle, most significant first.
  assign trial = {rem, dvd[LW-1]};
  assign ge    = trial >= {1'b0, den};
  assign diff  = trial - {1'b0, den};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvd  <= '0;
      rem  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      quot <= '0;
    end else if (start) begin
      dvd  <= {num, {FRAC{1'b0}}};
      rem  <= '0;
      cnt  <= IW'(LW);
      busy <= 1'b1;
      quot <= '0;
    end else if (busy) begin
      dvd  <= dvd << 1;
      rem  <= ge ? diff[DW-1:0] : trial[DW-1:0];
      quot <= {quot[LW-2:0], ge};
      cnt  <= cnt - IW'(1);
      if (cnt == IW'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/centroid_unit.sv
module centroid_unit
  import centroid_pkg::*;
#(
  parameter int ROWS    = 16,
  parameter int NCOL    = 8,
  parameter int ACW     = 7,
  parameter int MAXHITS = 64,
  parameter int TOTW    = 8,
  parameter int FRAC    = 4,
  localparam int RW     = $clog2(ROWS),
  localparam int CW     = $clog2(NCOL),
  localparam int XW     = ACW + FRAC,
  localparam int YW     = RW + FRAC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_weighted,
  input  logic [CW-1:0]   win_head,
  input  logic [ACW-1:0]  win_base,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_row,
  input  logic [CW-1:0]   wr_col,
  input  logic [TOTW-1:0] wr_tot,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [RW-1:0]   in_row,
  input  logic [CW-1:0]   in_col,
  input  logic            in_last,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XW-1:0]   out_x,
  output logic [YW-1:0]   out_y
);
  localparam int CNTW = $clog2(MAXHITS + 1);
  localparam int SWW  = CNTW + TOTW;
  localparam int NXW  = SWW + ACW;
  localparam int NYW  = SWW + RW;
  localparam int DXW  = CNTW + ACW;
  localparam int DYW  = CNTW + RW;

  cstate_t state;
  logic    first, mode_q, accept;
  logic [TOTW-1:0] tot;
  logic [CW-1:0]   ring_off;
  logic [ACW-1:0]  abs_col;

  logic [CNTW-1:0] cnt;
  logic [DXW-1:0]  sx_d;
  logic [DYW-1:0]  sy_d;
  logic [SWW-1:0]  wsum;
  logic [NXW-1:0]  sx_w;
  logic [NYW-1:0]  sy_w;

  logic            use_w, start, busy_x, busy_y;
  logic [SWW-1:0]  den;
  logic [NXW-1:0]  num_x;
  logic [NYW-1:0]  num_y;
  logic [NXW+FRAC-1:0] qx;
  logic [NYW+FRAC-1:0] qy;

  charge_store #(.ROWS(ROWS), .NCOL(NCOL), .TOTW(TOTW)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .wrow  (wr_row),
    .wcol  (wr_col),
    .wdata (wr_tot),
    .rrow  (in_row),
    .rcol  (in_col),
    .rdata (tot)
  );

  // Ring slot to absolute column.
  assign ring_off = in_col - win_head;
  assign abs_col  = win_base + ACW'(ring_off);

  assign in_ready  = (state == ST_COLLECT);
  assign out_valid = (state == ST_SHOW);
  assign accept    = in_valid && in_ready;
  assign start     = (state == ST_LAUNCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_COLLECT;
      first  <= 1'b1;
      mode_q <= 1'b0;
    end else begin
      if (accept) begin
        first <= in_last;
        if (first) mode_q <= mode_weighted;
      end
      unique case (state)
        ST_COLLECT: if (accept && in_last) state <= ST_LAUNCH;
        ST_LAUNCH:  state <= ST_WAIT;
        ST_WAIT:    if (!busy_x && !busy_y) state <= ST_SHOW;
        ST_SHOW:    if (out_ready) state <= ST_COLLECT;
        default:    state <= ST_COLLECT;
      endcase
    end
  end

  // Both sum sets run on every hit; the first beat of a cluster restarts them.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sx_d <= '0;
      sy_d <= '0;
      wsum <= '0;
      sx_w <= '0;
      sy_w <= '0;
    end else if (accept) begin
      cnt  <= (first ? '0 : cnt)  + CNTW'(1);
      sx_d <= (first ? '0 : sx_d) + DXW'(abs_col);
      sy_d <= (first ? '0 : sy_d) + DYW'(in_row);
      wsum <= (first ? '0 : wsum) + SWW'(tot);
      sx_w <= (first ? '0 : sx_w) + NXW'(tot) * NXW'(abs_col);
      sy_w <= (first ? '0 : sy_w) + NYW'(tot) * NYW'(in_row);
    end
  end

  // Zero total charge falls back to the plain mean.
  assign use_w = mode_q && (wsum != '0);
  assign den   = use_w ? wsum : SWW'(cnt);
  assign num_x = use_w ? sx_w : NXW'(sx_d);
  assign num_y = use_w ? sy_w : NYW'(sy_d);

  restoring_div #(.NW(NXW), .DW(SWW), .FRAC(FRAC)) u_div_x (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .num   (num_x),
    .den   (den),
    .busy  (busy_x),
    .quot  (qx)
  );

  restoring_div #(.NW(NYW), .DW(SWW), .FRAC(FRAC)) u_div_y (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .num   (num_y),
    .den   (den),
    .busy  (busy_y),
    .quot  (qy)
  );

  assign out_x = qx[XW-1:0];
  assign out_y = qy[YW-1:0];
endmodule

// File: rtl/centroid_unit_chk.sv
module centroid_unit_chk #(
  parameter int XW = 11,
  parameter int YW = 8,
  parameter int HW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          out_valid,
  input logic          out_ready,
  input logic [XW-1:0] out_x,
  input logic [YW-1:0] out_y,
  input logic [HW-1:0] x_hi,
  input logic [HW-1:0] y_hi
);
  p_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_last_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  p_reopen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)));

  p_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (x_hi == '0 && y_hi == '0));
endmodule

bind centroid_unit centroid_unit_chk #(.XW(XW), .YW(YW), .HW(SWW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_x     (out_x),
  .out_y     (out_y),
  .x_hi      (qx[NXW+FRAC-1:XW]),
  .y_hi      (qy[NYW+FRAC-1:YW])
);

// File: tb/sim_centroid_unit.sv
`timescale 1ns/1ps
module sim_centroid_unit;
  localparam int RW = 4, CW = 3, ACW = 7, XW = 11, YW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_weighted = 1'b0;
  logic [CW-1:0] win_head = '0;
  logic [ACW-1:0] win_base = '0;
  logic wr_en = 1'b0;
  logic [RW-1:0] wr_row = '0;
  logic [CW-1:0] wr_col = '0;
  logic [7:0] wr_tot = '0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [RW-1:0] in_row = '0;
  logic [CW-1:0] in_col = '0;
  logic in_ready, out_valid;
  logic [XW-1:0] out_x;
  logic [YW-1:0] out_y;

  int compared = 0, mismatched = 0;
  int chg [16][8];
  int nh;
  int hr [64];
  int hc [64];

  always #2 clk = ~clk;

  centroid_unit u0 (
    .clk(clk), .rst_n(rst_n), .mode_weighted(mode_weighted),
    .win_head(win_head), .win_base(win_base),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_tot(wr_tot),
    .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
    .in_col(in_col), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x), .out_y(out_y)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_charge(input int r, input int c, input int v);
    wr_row = RW'(r); wr_col = CW'(c); wr_tot = 8'(v); wr_en = 1'b1;
    chg[r][c] = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(input int r, input int c, input bit last);
    in_row = RW'(r); in_col = CW'(c); in_last = last; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Sends hr/hc[0..nh-1] as one cluster and checks the centre.
  task automatic run_cluster(input int md, input bit flip, input int head,
                             input int base, input string tag);
    longint sw = 0, sx = 0, sy = 0, sxd = 0, syd = 0, ex, ey;
    win_head = CW'(head); win_base = ACW'(base); mode_weighted = md[0];
    for (int i = 0; i < nh; i++) begin
      int ac = (base + ((hc[i] - head) & 7)) & 127;
      int t  = chg[hr[i]][hc[i]];
      sw += t; sx += t * ac; sy += t * hr[i]; sxd += ac; syd += hr[i];
      push(hr[i], hc[i], i == nh - 1);
      if (flip && i == 0) mode_weighted = ~mode_weighted;
    end
    if (md != 0 && sw != 0) begin ex = (sx * 16) / sw; ey = (sy * 16) / sw; end
    else begin ex = (sxd * 16) / nh; ey = (syd * 16) / nh; end
    // R2: input offered while the result is pending is ignored.
    in_row = 4'd3; in_col = 3'd2; in_last = 1'b1; in_valid = 1'b1;
    while (!out_valid) begin
      chk("R2 in_ready low while busy", in_ready, 0);
      @(negedge clk);
    end
    chk({tag, " x"}, out_x, ex);
    chk({tag, " y"}, out_y, ey);
    chk("R1 in_ready with out_valid", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 valid held", out_valid, 1);
    chk("R3 x held", out_x, ex);
    chk("R3 y held", out_y, ey);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R2 in_ready after handshake", in_ready, 1);
    chk("R2 out_valid dropped", out_valid, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 in_ready after reset", in_ready, 1);
    chk("R10 out_valid after reset", out_valid, 0);

    // R7: load the store; row 15 and slot 7 carry zero charge.
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 8; c++)
        wr_charge(r, c, (r == 15 || c == 7) ? 0 : ((r * 37 + c * 11 + 5) % 256));

    // R4 and R8: single hits over every pixel, several ring positions and bases.
    for (int k = 0; k < 4; k++) begin
      int head = (k % 2) * 5;
      int base = (k / 2) * 123;
      for (int r = 0; r < 16; r++)
        for (int c = 0; c < 8; c++) begin
          nh = 1; hr[0] = r; hc[0] = c;
          run_cluster(0, 0, head, base, "R8 single hit");
        end
    end

    // R4 and R5: 3x3 blocks swept over the window in both modes.
    for (int md = 0; md < 2; md++)
      for (int r0 = 0; r0 < 14; r0++)
        for (int c0 = 0; c0 < 6; c0++) begin
          nh = 0;
          for (int dr = 0; dr < 3; dr++)
            for (int dc = 0; dc < 3; dc++) begin
              hr[nh] = r0 + dr; hc[nh] = (c0 + dc + 4) & 7; nh++;
            end
          run_cluster(md, 0, 4, 60, md != 0 ? "R5 weighted block" : "R4 plain block");
        end

    // R6: weighted mode on pixels that all carry zero charge.
    nh = 4;
    for (int i = 0; i < 4; i++) begin hr[i] = 15; hc[i] = i * 2 + 1; end
    run_cluster(1, 0, 0, 10, "R6 zero charge fallback");
    nh = 3; hr[0] = 4; hc[0] = 7; hr[1] = 5; hc[1] = 7; hr[2] = 9; hc[2] = 7;
    run_cluster(1, 0, 2, 100, "R6 zero charge slot");

    // R9: mode changed after the first beat.
    nh = 3; hr[0] = 1; hc[0] = 0; hr[1] = 6; hc[1] = 2; hr[2] = 11; hc[2] = 5;
    run_cluster(1, 1, 0, 20, "R9 weighted kept");
    run_cluster(0, 1, 3, 40, "R9 plain kept");

    // R7: rewrite one pixel and use it again.
    wr_charge(2, 3, 200);
    nh = 2; hr[0] = 2; hc[0] = 3; hr[1] = 2; hc[1] = 4;
    run_cluster(1, 0, 0, 0, "R7 rewritten charge");
    wr_charge(2, 3, 1);
    run_cluster(1, 0, 0, 0, "R7 rewritten again");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule